// File: doc/BRIEF.md
# Thermal Clock Throttle Controller

This block decides the clock multiplier for a compute engine whose clock frequency in MHz is twice the multiplier. It takes periodic temperature samples, compares them with a target temperature and a hysteresis band, and steps the multiplier down one notch at a time while the part runs hot. The steps are spaced by a minimum interval in clock cycles. Each step down also lowers a cooling ceiling, which caps any multiplier that is requested later.

When the part cools, the ceiling recovers in one of two ways. Just below the target, it creeps up by one, but only while the multiplier sits at the ceiling. Once the temperature is clearly below the band, it snaps back to the absolute ceiling. A requested multiplier, such as a tuning loop's choice, is clamped to the range between the floor and the current ceiling before it takes effect. Every change of the multiplier is flagged with a one-cycle strobe, so the downstream clock generator knows to reprogram.

Top module: `thermal_throttle`

## Requirements
- R1: Reset values: multiplier 95, cooling ceiling 125, change strobe low.
- R2: A temperature sample is a 12-bit two's complement value with 2 fraction bits (quarter degrees). It is rounded to whole degrees with halves going up, that is floor((sample+2)/4), before any comparison. Target is an 8-bit signed whole-degree value and hysteresis is a 5-bit unsigned whole-degree value.
- R3: A valid sample whose rounded value exceeds target plus hysteresis, arriving while the rate gate is open, is a throttle event. The multiplier drops by one and the ceiling becomes the new multiplier; both are visible after the next clock edge.
- R4: The rate gate is open after reset. A throttle event closes it for RATE_CYCLES cycles, so the next event can occur no earlier than RATE_CYCLES cycles later. Hot samples that arrive while the gate is closed change nothing.
- R5: The multiplier never goes below 1. A throttle event at 1 keeps the multiplier and the ceiling at 1 and still restarts the rate gate.
- R6: A valid sample whose rounded value is below target minus hysteresis restores the ceiling to 125 in one step.
- R7: A valid sample below target but not below target minus hysteresis raises the ceiling by one if the ceiling is below 125 and the multiplier equals the ceiling. Otherwise the ceiling is unchanged.
- R8: A sample with temp_valid low has no effect on the multiplier, the ceiling or the rate gate.
- R9: With req_valid high, the multiplier becomes req_mult clamped to the range 1 to the ceiling as updated in the same cycle. A request that meets a throttle event in the same cycle is dropped.
- R10: mult_chg is high for exactly the cycle after an edge at which the multiplier changed value, and low at all other times.
- R11: At all times 1 <= multiplier <= ceiling <= 125.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_valid | input | 1 | Temperature sample strobe |
| temp_sample | input | 12 | Temperature, two's complement, quarter degrees |
| target_c | input | 8 | Target temperature, signed whole degrees |
| hyst_c | input | 5 | Hysteresis band, whole degrees |
| req_valid | input | 1 | Multiplier request strobe |
| req_mult | input | 7 | Requested multiplier |
| mult_out | output | 7 | Current clock multiplier |
| ceil_out | output | 7 | Cooling ceiling |
| mult_chg | output | 1 | One-cycle pulse on multiplier change |

## Verification
The assertions check several properties on every cycle. They check the ordering floor <= multiplier <= ceiling <= absolute ceiling, the single-notch step and the floor hold on a throttle event, and that the ceiling follows the throttled value. They also check the snap-back on a cold sample, the closing and reload of the rate gate, that idle inputs hold state, and that the strobe tracks multiplier changes. The bench's scenarios are what show the rest. They show the rounding boundary at half degrees, the exact spacing of throttle events under sustained heat, and the one-step creep that depends on the multiplier sitting at the ceiling. They also show the exhaustive clamp of every request code and the priority when a request meets a throttle event. These are swept over several target and band settings with rising and falling temperature ramps.

// File: rtl/tt_throttle_pkg.sv
package tt_throttle_pkg;
  // Thermal zone of one rounded sample relative to target and band
  typedef enum logic [1:0] {
    ZONE_WARM = 2'd0,  // at or above target, not above the band
    ZONE_HOT  = 2'd1,  // above target + hysteresis
    ZONE_MILD = 2'd2,  // below target, inside the band
    ZONE_COLD = 2'd3   // below target - hysteresis
  } tt_zone_e;
endpackage

// File: rtl/tt_zone_classify.sv
module tt_zone_classify
  import tt_throttle_pkg::*;
#(
  parameter int TEMP_W = 12,
  parameter int FRAC_W = 2,
  parameter int TGT_W  = 8,
  parameter int HYST_W = 5
) (
  input  logic [TEMP_W-1:0] temp_sample,
  input  logic [TGT_W-1:0]  target_c,
  input  logic [HYST_W-1:0] hyst_c,
  output tt_zone_e          zone
);
  localparam int CMP_W = TEMP_W + TGT_W + HYST_W + 2;

  logic signed [TEMP_W:0]  samp_ext;
  logic signed [TEMP_W:0]  rounded;
  logic signed [CMP_W-1:0] temp_c;
  logic signed [CMP_W-1:0] tgt_c;
  logic signed [CMP_W-1:0] band_c;
  logic                    is_hot, is_cold, is_below;

  assign samp_ext = (TEMP_W+1)'($signed(temp_sample));

  generate
    if (FRAC_W > 0) begin : g_round
      localparam logic signed [TEMP_W:0] HALF = (TEMP_W+1)'(1 << (FRAC_W-1));
      logic signed [TEMP_W:0] biased;
      assign biased  = samp_ext + HALF;
      assign rounded = biased >>> FRAC_W;
    end else begin : g_whole
      assign rounded = samp_ext;
    end
  endgenerate

  assign temp_c = CMP_W'(rounded);
  assign tgt_c  = CMP_W'($signed(target_c));
  assign band_c = CMP_W'($signed({1'b0, hyst_c}));

  assign is_hot   = temp_c > (tgt_c + band_c);
  assign is_cold  = temp_c < (tgt_c - band_c);
  assign is_below = temp_c < tgt_c;

  always_comb begin
    if (is_hot)        zone = ZONE_HOT;
    else if (is_cold)  zone = ZONE_COLD;
    else if (is_below) zone = ZONE_MILD;
    else               zone = ZONE_WARM;
  end
endmodule

// File: rtl/tt_rate_gate.sv
module tt_rate_gate #(
  parameter int RATE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic ready
);
  localparam int CNT_W = (RATE_CYCLES < 2) ? 1 : $clog2(RATE_CYCLES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(RATE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             cnt_en;

  assign ready  = (cnt_q == '0);
  assign cnt_en = fire || !ready;

  always_comb begin
    if (fire) cnt_nxt = RELOAD;
    else      cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  // R4: every event reloads the full interval
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == RELOAD));

  generate
    if (RATE_CYCLES > 1) begin : g_gap
      // R4: gate closed in the cycle after an event
      p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !ready);
    end
  endgenerate
endmodule

// File: rtl/tt_ceiling_track.sv
module tt_ceiling_track
  import tt_throttle_pkg::*;
#(
  parameter int MULT_W   = 7,
  parameter int MULT_ABS = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              temp_valid,
  input  tt_zone_e          zone,
  input  logic              fire,
  input  logic [MULT_W-1:0] mult_q,
  input  logic [MULT_W-1:0] mult_dn,
  output logic [MULT_W-1:0] ceil_q,
  output logic [MULT_W-1:0] ceil_nxt
);
  localparam logic [MULT_W-1:0] ABS_V = MULT_W'(MULT_ABS);

  logic recover;
  logic ceil_en;

  assign recover = temp_valid && (ceil_q < ABS_V) &&
                   ((zone == ZONE_COLD) || (zone == ZONE_MILD));

  always_comb begin
    ceil_nxt = ceil_q;
    if (fire) begin
      ceil_nxt = mult_dn;
    end else if (recover) begin
      if (zone == ZONE_COLD)    ceil_nxt = ABS_V;
      else if (mult_q == ceil_q) ceil_nxt = ceil_q + 1'b1;
    end
  end

  assign ceil_en = fire || recover;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ceil_q <= ABS_V;
    else if (ceil_en) ceil_q <= ceil_nxt;
  end

  // R3: ceiling follows the throttled multiplier
  p_ceil_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (ceil_q == $past(mult_dn)));

  // R6: a cold sample leaves the ceiling at the absolute value
  p_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_valid && zone == ZONE_COLD) |=> (ceil_q == ABS_V));

  // R11: ceiling never above the absolute value
  p_ceil_abs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ceil_q <= ABS_V);
endmodule

// File: rtl/thermal_throttle.sv
module thermal_throttle
  import tt_throttle_pkg::*;
#(
  parameter int MULT_W      = 7,
  parameter int MULT_MIN    = 1,
  parameter int MULT_ABS    = 125,
  parameter int MULT_DEF    = 95,
  parameter int TEMP_W      = 12,
  parameter int FRAC_W      = 2,
  parameter int TGT_W       = 8,
  parameter int HYST_W      = 5,
  parameter int RATE_CYCLES = 50_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              temp_valid,
  input  logic [TEMP_W-1:0] temp_sample,
  input  logic [TGT_W-1:0]  target_c,
  input  logic [HYST_W-1:0] hyst_c,
  input  logic              req_valid,
  input  logic [MULT_W-1:0] req_mult,
  output logic [MULT_W-1:0] mult_out,
  output logic [MULT_W-1:0] ceil_out,
  output logic              mult_chg
);
  localparam logic [MULT_W-1:0] MIN_V = MULT_W'(MULT_MIN);
  localparam logic [MULT_W-1:0] DEF_V = MULT_W'(MULT_DEF);

  tt_zone_e          zone;
  logic              ready, fire;
  logic [MULT_W-1:0] mult_q, mult_nxt, mult_dn;
  logic [MULT_W-1:0] ceil_q, ceil_nxt;
  logic [MULT_W-1:0] req_clamped;
  logic              mult_en;
  logic              chg_q, chg_nxt;

  tt_zone_classify #(
    .TEMP_W (TEMP_W),
    .FRAC_W (FRAC_W),
    .TGT_W  (TGT_W),
    .HYST_W (HYST_W)
  ) u_classify (
    .temp_sample (temp_sample),
    .target_c    (target_c),
    .hyst_c      (hyst_c),
    .zone        (zone)
  );

  tt_rate_gate #(
    .RATE_CYCLES (RATE_CYCLES)
  ) u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .ready (ready)
  );

  assign fire    = temp_valid && (zone == ZONE_HOT) && ready;
  assign mult_dn = (mult_q > MIN_V) ? (mult_q - 1'b1) : MIN_V;

  tt_ceiling_track #(
    .MULT_W   (MULT_W),
    .MULT_ABS (MULT_ABS)
  ) u_ceil (
    .clk        (clk),
    .rst_n      (rst_n),
    .temp_valid (temp_valid),
    .zone       (zone),
    .fire       (fire),
    .mult_q     (mult_q),
    .mult_dn    (mult_dn),
    .ceil_q     (ceil_q),
    .ceil_nxt   (ceil_nxt)
  );

  // Request clamp against the ceiling as updated this cycle
  always_comb begin
    if (req_mult < MIN_V)         req_clamped = MIN_V;
    else if (req_mult > ceil_nxt) req_clamped = ceil_nxt;
    else                          req_clamped = req_mult;
  end

  always_comb begin
    if (fire)           mult_nxt = mult_dn;
    else if (req_valid) mult_nxt = req_clamped;
    else                mult_nxt = mult_q;
  end

  assign mult_en = fire || req_valid;
  assign chg_nxt = mult_en && (mult_nxt != mult_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mult_q <= DEF_V;
    else if (mult_en) mult_q <= mult_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_q <= 1'b0;
    else        chg_q <= chg_nxt;
  end

  assign mult_out = mult_q;
  assign ceil_out = ceil_q;
  assign mult_chg = chg_q;

  // R11: ordering between floor, multiplier and ceiling
  p_mult_le_ceil_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mult_q <= ceil_q);
  // R5: floor is never crossed
  p_mult_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mult_q >= MIN_V);
  // R3: one notch per throttle event
  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mult_q > MIN_V) |=> (mult_q == $past(mult_q) - 1'b1));
  // R5: event at the floor holds the floor
  p_floor_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mult_q == MIN_V) |=> (mult_q == MIN_V));
  // R8: no strobes, no movement
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!temp_valid && !req_valid) |=> ($stable(mult_q) && $stable(ceil_q)));
  // R9: an in-range request is taken as is
  p_req_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !fire && req_mult >= MIN_V && req_mult <= ceil_nxt)
      |=> (mult_q == $past(req_mult)));
  // R10: strobe marks exactly the cycles after a change
  p_chg_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mult_chg == (mult_q != $past(mult_q)));
endmodule

// File: tb/thermal_throttle_test.sv
`timescale 1ns/1ps
module thermal_throttle_test;
  localparam int RATE = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       temp_valid;
  logic [11:0] temp_sample;
  logic [7:0] target_c;
  logic [4:0] hyst_c;
  logic       req_valid;
  logic [6:0] req_mult;
  logic [6:0] mult_out, ceil_out;
  logic       mult_chg;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // model state
  int m_mult, m_ceil, m_cnt;
  bit m_chg;
  int tgt, hy;

  always #10 clk = ~clk;

  thermal_throttle #(.RATE_CYCLES(RATE)) uut (
    .clk (clk), .rst_n (rst_n),
    .temp_valid (temp_valid), .temp_sample (temp_sample),
    .target_c (target_c), .hyst_c (hyst_c),
    .req_valid (req_valid), .req_mult (req_mult),
    .mult_out (mult_out), .ceil_out (ceil_out), .mult_chg (mult_chg)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Drive one cycle at a negedge, advance the model, compare at the next negedge.
  task automatic step(input bit tv, input int ts, input bit rv, input int rq);
    int rt, nm, nc;
    bit hot, cold, mild, ready, evt;
    string tag;
    temp_valid  = tv;
    temp_sample = 12'(ts);
    req_valid   = rv;
    req_mult    = 7'(rq);
    target_c    = 8'(tgt);
    hyst_c      = 5'(hy);
    rt    = (ts + 2) >>> 2;                  // R2 rounding, halves up
    hot   = rt > tgt + hy;
    cold  = rt < tgt - hy;
    mild  = !hot && !cold && (rt < tgt);
    ready = (m_cnt == 0);
    evt   = tv && hot && ready;
    nm = m_mult; nc = m_ceil;
    if (evt) begin
      nm = (m_mult > 1) ? m_mult - 1 : 1;
      nc = nm;
    end else if (tv && m_ceil < 125 && (cold || mild)) begin
      if (cold) nc = 125;
      else if (m_mult == m_ceil) nc = m_ceil + 1;
    end
    if (!evt && rv) nm = (rq < 1) ? 1 : ((rq > nc) ? nc : rq);
    if (evt) m_cnt = RATE - 1;
    else if (m_cnt > 0) m_cnt--;
    m_chg  = (nm != m_mult);
    if (evt)              tag = (m_mult == 1) ? "R5" : "R3";
    else if (tv && hot)   tag = "R4";
    else if (tv && cold)  tag = "R6";
    else if (tv && mild)  tag = "R7";
    else if (rv)          tag = "R9";
    else if (!tv)         tag = "R8";
    else                  tag = "R2";
    m_mult = nm; m_ceil = nc;
    @(negedge clk);
    check(tag, "mult", int'(mult_out), m_mult);
    check(tag, "ceil", int'(ceil_out), m_ceil);
    check("R10", "chg", int'(mult_chg), int'(m_chg));
    check("R11", "order", int'(mult_out >= 1 && mult_out <= ceil_out && ceil_out <= 125), 1);
  endtask

  initial begin
    #(200000 * 20);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    rst_n = 1'b0; temp_valid = 0; temp_sample = '0; req_valid = 0; req_mult = '0;
    tgt = 60; hy = 4; target_c = 8'(tgt); hyst_c = 5'(hy);
    m_mult = 95; m_ceil = 125; m_cnt = 0; m_chg = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "mult", int'(mult_out), 95);
    check("R1", "ceil", int'(ceil_out), 125);
    check("R1", "chg",  int'(mult_chg), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 exhaustive request codes with the ceiling at 125
    for (int rq = 0; rq < 128; rq++) step(0, 0, 1, rq);
    check("R9", "clamp_high", int'(mult_out), 125);
    step(0, 0, 1, 0);
    check("R9", "clamp_low", int'(mult_out), 1);
    step(0, 0, 1, 95);

    // R2 rounding boundary at target 50, band 0
    tgt = 50; hy = 0;
    step(1, 50*4 + 1, 0, 0);
    check("R2", "quarter_not_hot", int'(mult_out), 95);
    step(1, 50*4 + 2, 0, 0);
    check("R2", "half_rounds_up", int'(mult_out), 94);

    // R4 sustained heat: events spaced by RATE
    for (int i = 0; i < 4*RATE; i++) step(1, 70*4, 0, 0);
    check("R4", "spaced_steps", int'(mult_out), 90);

    // R8 invalid hot samples while the gate is open
    for (int i = 0; i < RATE + 2; i++) step(0, 90*4, 0, 0);
    check("R8", "invalid_hold", int'(mult_out), 90);

    // R9 request meets a throttle event: request dropped
    step(1, 70*4, 1, 80);
    check("R9", "req_dropped", int'(mult_out), 89);

    // R7 creep: band 4, sample at 48
    tgt = 50; hy = 4;
    step(1, 48*4, 0, 0);
    check("R7", "creep", int'(ceil_out), 90);
    step(1, 48*4, 0, 0);
    check("R7", "no_creep_below_ceil", int'(ceil_out), 90);
    for (int i = 0; i < 6; i++) begin
      step(0, 0, 1, 127);
      step(1, 48*4, 0, 0);
    end
    check("R7", "creep_with_requests", int'(ceil_out), 96);

    // R6 cold snap-back
    step(1, 40*4, 0, 0);
    check("R6", "restore", int'(ceil_out), 125);

    // R5 floor under long heat
    for (int i = 0; i < 130*RATE; i++) step(1, 100*4, 0, 0);
    check("R5", "floor_mult", int'(mult_out), 1);
    check("R5", "floor_ceil", int'(ceil_out), 1);
    step(1, 40*4, 1, 125);

    // Sweep targets and bands with rising then falling ramps
    for (int t = 0; t < 3; t++) begin
      for (int h = 0; h < 4; h++) begin
        tgt = 30 + 25*t; hy = 2*h + (h == 3 ? 10 : 0);
        for (int s = tgt*4 - 80; s <= tgt*4 + 80; s += 3)
          step((s % 7) != 0, s, (s % 11) == 0, (s * 13) & 127);
        for (int s = tgt*4 + 80; s >= tgt*4 - 80; s -= 2)
          step((s % 5) != 0, s, (s % 9) == 0, 127 - ((s * 7) & 127));
      end
    end
    // negative temperatures
    tgt = -10; hy = 3;
    for (int s = -120; s <= 40; s++) step(1, s, (s % 6) == 0, 127);

    report();
  end
endmodule